// File: doc/BRIEF.md
# Sectioned Recursive Filter

This block realises a recursive (feedback) digital filter of order ORDER as a chain or a bank of small sections. There are (ORDER+1)/2 sections. Each is a second-order section with three feed-forward and two feedback coefficients. When ORDER is odd, the last section is first order. All coefficients are fixed-point parameters with FRAC fractional bits. Every section keeps its state at one common width, SW.

A single structure parameter chooses how the sections combine.

- **Serial mode:** the input sample is first multiplied by a gain K. The result then passes through every section in turn. Each intermediate result is quantised to SW bits before it reaches the next section.
- **Parallel mode:** every section receives the raw input and uses only its first two feed-forward taps. The section outputs are added to a K-scaled copy of the input. That copy is registered so that it lines up with the section outputs.

The coefficients are factored offline and supplied as parameters. The block has a synchronous active-high reset and a clock enable. A new sample is taken on every enabled clock edge.

Top module: `iir_sos_top`

## Requirements
- R1: The block has (ORDER+1)/2 sections. When ORDER is odd, the last section is first order: its third feed-forward coefficient and its second feedback coefficient have no effect on yout, even when they are nonzero.
- R2: In serial mode (MODE = COMB_SERIAL), the first section receives sat(floor(K*xin / 2^FRAC)). Section k+1 receives the registered output of section k. yout is the registered output of the last section, so a sample first reaches yout after (ORDER+1)/2 enabled edges. Here sat() clamps to the signed SW-bit range.
- R3: On each enabled edge, a section updates its output to y = sat(floor((a0*x + a1*x1 + a2*x2 - b1*y1 - b2*y2) / 2^FRAC)). In this equation:
  - x is the current section input;
  - x1 and x2 are the section inputs from the previous two enabled edges;
  - y1 and y2 are the section outputs from the previous two enabled edges.
- R4: In parallel mode (MODE = COMB_PARALLEL), every section receives xin sign-extended to SW bits, and each section's a2 coefficient has no effect. yout = sat(sum of all section outputs + g), where g is sat(floor(K*xin / 2^FRAC)) registered on the same edge as the sections. The latency is one enabled edge.
- R5: srst high at a clock edge clears all section and gain state to zero, so yout is 0 after that edge. srst takes priority over clken.
- R6: While clken is low and srst is low, no state changes and yout holds its value.
- R7: From an all-zero state, a zero input keeps the state and yout at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clock | input | 1 | Clock; all state changes on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| clken | input | 1 | Sample enable, active high |
| xin | input | DW | Signed input sample |
| yout | output | SW | Signed filtered output |

## Verification
The assertions check on every cycle that:
- reset empties the state and zeroes yout;
- a low enable freezes yout;
- an all-zero state with zero input stays all zero;
- an all-zero state always shows as a zero output.

Only the bench scenarios can show the following, because they need the arithmetic itself:
- the exact difference equation of each section;
- the per-stage quantisation and saturation in serial mode;
- the one-cycle alignment of the gain path in parallel mode;
- the fact that coefficients of the odd tail section, and every a2 in parallel mode, have no effect.

The bench runs both structures side by side. It uses impulse, full input sweep, pseudo-random, saturating and enable-gated input patterns.

// File: rtl/iir_sos_pkg.sv
package iir_sos_pkg;

    localparam int MAX_SEC = 8;
    localparam int ACCW    = 64;

    typedef enum logic {
        COMB_SERIAL   = 1'b0,
        COMB_PARALLEL = 1'b1
    } comb_mode_e;

    typedef struct packed {
        logic signed [31:0] a0;
        logic signed [31:0] a1;
        logic signed [31:0] a2;
        logic signed [31:0] b1;
        logic signed [31:0] b2;
    } sec_coef_t;

    // clamp a wide signed value to the signed range of w bits
    function automatic logic signed [ACCW-1:0] sat_clip(
        input logic signed [ACCW-1:0] v,
        input int unsigned            w
    );
        logic signed [ACCW-1:0] one, hi, lo;
        one = 1;
        hi  = (one <<< (w - 1)) - one;
        lo  = ~hi;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/iir_sos_section.sv
module iir_sos_section
    import iir_sos_pkg::*;
#(
    parameter int        SW          = 16,
    parameter int        FRAC        = 6,
    parameter bit        FIRST_ORDER = 1'b0,
    parameter bit        NO_A2       = 1'b0,
    parameter sec_coef_t COEF        = '0
) (
    input  logic                 clock,
    input  logic                 srst,
    input  logic                 clken,
    input  logic signed [SW-1:0] x_in,
    output logic signed [SW-1:0] y_out,
    output logic                 idle
);

    localparam bit DROP_A2 = FIRST_ORDER || NO_A2;
    localparam bit DROP_B2 = FIRST_ORDER;

    localparam logic signed [ACCW-1:0] CA0 = ACCW'(COEF.a0);
    localparam logic signed [ACCW-1:0] CA1 = ACCW'(COEF.a1);
    localparam logic signed [ACCW-1:0] CA2 = DROP_A2 ? '0 : ACCW'(COEF.a2);
    localparam logic signed [ACCW-1:0] CB1 = ACCW'(COEF.b1);
    localparam logic signed [ACCW-1:0] CB2 = DROP_B2 ? '0 : ACCW'(COEF.b2);

    logic signed [SW-1:0]   x1, x2, y1, y2;
    logic signed [SW-1:0]   y_next;
    logic signed [ACCW-1:0] acc;

    always_comb begin
        acc = CA0 * ACCW'(x_in) + CA1 * ACCW'(x1) + CA2 * ACCW'(x2)
            - CB1 * ACCW'(y1) - CB2 * ACCW'(y2);
        y_next = SW'(sat_clip(acc >>> FRAC, SW));
    end

    always_ff @(posedge clock) begin
        if (srst) begin
            x1 <= '0;
            y1 <= '0;
        end else if (clken) begin
            x1 <= x_in;
            y1 <= y_next;
        end
    end

    // second input tap exists only when a2 can matter
    if (DROP_A2) begin : g_no_x2
        assign x2 = '0;
    end else begin : g_x2
        always_ff @(posedge clock) begin
            if (srst)       x2 <= '0;
            else if (clken) x2 <= x1;
        end
    end

    // second feedback tap is absent in a first-order tail
    if (DROP_B2) begin : g_no_y2
        assign y2 = '0;
    end else begin : g_y2
        always_ff @(posedge clock) begin
            if (srst)       y2 <= '0;
            else if (clken) y2 <= y1;
        end
    end

    assign y_out = y1;
    assign idle  = (x1 == '0) && (x2 == '0) && (y1 == '0) && (y2 == '0);

endmodule

// File: rtl/iir_sos_gain.sv
module iir_sos_gain
    import iir_sos_pkg::*;
#(
    parameter int                 DW   = 8,
    parameter int                 SW   = 16,
    parameter int                 FRAC = 6,
    parameter logic signed [31:0] GAIN = 32'sd64,
    parameter bit                 REG  = 1'b0
) (
    input  logic                 clock,
    input  logic                 srst,
    input  logic                 clken,
    input  logic signed [DW-1:0] x_in,
    output logic signed [SW-1:0] g_out,
    output logic                 idle
);

    localparam logic signed [ACCW-1:0] CK = ACCW'(GAIN);

    logic signed [SW-1:0] scaled;

    always_comb begin
        scaled = SW'(sat_clip((CK * ACCW'(x_in)) >>> FRAC, SW));
    end

    if (REG) begin : g_reg
        logic signed [SW-1:0] held;
        always_ff @(posedge clock) begin
            if (srst)       held <= '0;
            else if (clken) held <= scaled;
        end
        assign g_out = held;
        assign idle  = (held == '0);
    end else begin : g_comb
        logic unused_ctl;
        assign unused_ctl = clock ^ srst ^ clken;
        assign g_out = scaled;
        assign idle  = 1'b1;
    end

endmodule

// File: rtl/iir_sos_sum.sv
module iir_sos_sum
    import iir_sos_pkg::*;
#(
    parameter int NSEC = 3,
    parameter int SW   = 16
) (
    input  logic signed [SW-1:0] sec_y [NSEC],
    input  logic signed [SW-1:0] g_in,
    output logic signed [SW-1:0] sum_out
);

    logic signed [ACCW-1:0] acc;

    always_comb begin
        acc = ACCW'(g_in);
        for (int k = 0; k < NSEC; k++) begin
            acc = acc + ACCW'(sec_y[k]);
        end
        sum_out = SW'(sat_clip(acc, SW));
    end

endmodule

// File: rtl/iir_sos_top.sv
module iir_sos_top
    import iir_sos_pkg::*;
#(
    parameter int                      ORDER = 5,
    parameter comb_mode_e              MODE  = COMB_SERIAL,
    parameter int                      DW    = 8,
    parameter int                      CW    = 8,
    parameter int                      FRAC  = 6,
    parameter int                      SW    = 16,
    parameter logic [MAX_SEC*CW-1:0]   A0    = 64'h0000_0000_0030_4020,
    parameter logic [MAX_SEC*CW-1:0]   A1    = 64'h0000_0000_0010_E010,
    parameter logic [MAX_SEC*CW-1:0]   A2    = 64'h0000_0000_0028_1008,
    parameter logic [MAX_SEC*CW-1:0]   B1    = 64'h0000_0000_00E8_10E0,
    parameter logic [MAX_SEC*CW-1:0]   B2    = 64'h0000_0000_0014_0810,
    parameter logic signed [CW-1:0]    K     = 8'sd48
) (
    input  logic                 clock,
    input  logic                 srst,
    input  logic                 clken,
    input  logic signed [DW-1:0] xin,
    output logic signed [SW-1:0] yout
);

    localparam int NSEC     = (ORDER + 1) / 2;
    localparam bit ODD      = (ORDER % 2) == 1;
    localparam bit PARALLEL = (MODE == COMB_PARALLEL);

    logic signed [SW-1:0] sec_in [NSEC];
    logic signed [SW-1:0] sec_y  [NSEC];
    logic [NSEC-1:0]      sec_idle;
    logic signed [SW-1:0] g_val;
    logic                 g_idle;
    logic                 state_zero;

    iir_sos_gain #(
        .DW(DW), .SW(SW), .FRAC(FRAC), .GAIN(32'(K)), .REG(PARALLEL)
    ) u_gain (
        .clock(clock), .srst(srst), .clken(clken),
        .x_in(xin), .g_out(g_val), .idle(g_idle)
    );

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        localparam sec_coef_t C = '{
            a0: 32'(signed'(A0[k*CW +: CW])),
            a1: 32'(signed'(A1[k*CW +: CW])),
            a2: 32'(signed'(A2[k*CW +: CW])),
            b1: 32'(signed'(B1[k*CW +: CW])),
            b2: 32'(signed'(B2[k*CW +: CW]))
        };

        if (PARALLEL) begin : g_in_par
            assign sec_in[k] = SW'(xin);
        end else if (k == 0) begin : g_in_head
            assign sec_in[k] = g_val;
        end else begin : g_in_chain
            assign sec_in[k] = sec_y[k-1];
        end

        iir_sos_section #(
            .SW(SW), .FRAC(FRAC),
            .FIRST_ORDER(ODD && (k == NSEC - 1)),
            .NO_A2(PARALLEL),
            .COEF(C)
        ) u_sec (
            .clock(clock), .srst(srst), .clken(clken),
            .x_in(sec_in[k]), .y_out(sec_y[k]), .idle(sec_idle[k])
        );
    end

    if (PARALLEL) begin : g_out_par
        iir_sos_sum #(.NSEC(NSEC), .SW(SW)) u_sum (
            .sec_y(sec_y), .g_in(g_val), .sum_out(yout)
        );
    end else begin : g_out_ser
        assign yout = sec_y[NSEC-1];
    end

    assign state_zero = (&sec_idle) && g_idle;

endmodule

// File: rtl/iir_sos_chk.sv
module iir_sos_chk #(
    parameter int DW = 8,
    parameter int SW = 16
) (
    input logic                 clock,
    input logic                 srst,
    input logic                 clken,
    input logic signed [DW-1:0] xin,
    input logic signed [SW-1:0] yout,
    input logic                 state_zero
);

    // R5: reset empties every section and the gain register
    // (srst is the antecedent, so it cannot also disable the check)
    p_reset_state_r5: assert property (@(posedge clock)
        srst |=> state_zero);

    // R5: output is zero after a reset edge
    p_reset_out_r5: assert property (@(posedge clock)
        srst |=> (yout == '0));

    // R6: no enable, no change at the output
    p_hold_r6: assert property (@(posedge clock) disable iff (srst)
        !clken |=> $stable(yout));

    // R7: zero input from rest stays at rest
    p_rest_r7: assert property (@(posedge clock) disable iff (srst)
        (clken && xin == '0 && state_zero) |=> state_zero);

    // R7: an empty state always reads out as zero
    p_rest_out_r7: assert property (@(posedge clock) disable iff (srst)
        state_zero |-> (yout == '0));

endmodule

bind iir_sos_top iir_sos_chk #(.DW(DW), .SW(SW)) u_chk (
    .clock(clock), .srst(srst), .clken(clken),
    .xin(xin), .yout(yout), .state_zero(state_zero)
);

// File: tb/test_iir_sos_top.sv
`timescale 1ns/1ps
module test_iir_sos_top;
    import iir_sos_pkg::*;

    logic              clock = 1'b0;
    logic              srst  = 1'b1;
    logic              clken = 1'b0;
    logic signed [7:0] xin   = '0;
    logic signed [15:0] yout_s, yout_p;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clock = ~clock;   // 125 MHz

    iir_sos_top i_iir_sos_top (
        .clock(clock), .srst(srst), .clken(clken), .xin(xin), .yout(yout_s)
    );

    iir_sos_top #(.MODE(COMB_PARALLEL)) i_iir_sos_top_par (
        .clock(clock), .srst(srst), .clken(clken), .xin(xin), .yout(yout_p)
    );

    // coefficients (Q.6), section 2 is the first-order tail
    longint a0[3] = '{32, 64, 48};
    longint a1[3] = '{16, -32, 16};
    longint a2[3] = '{8, 16, 40};
    longint b1[3] = '{-32, 16, -24};
    longint b2[3] = '{16, 8, 20};
    longint kg    = 48;

    // model state: [mode][section], mode 0 serial, 1 parallel
    longint mx1[2][3], mx2[2][3], my1[2][3], my2[2][3];
    longint mkreg;

    function automatic longint sat16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint sec_eval(int m, int k, longint xi);
        longint a2e, b2e;
        a2e = (k == 2 || m == 1) ? 0 : a2[k];
        b2e = (k == 2) ? 0 : b2[k];
        return sat16((a0[k]*xi + a1[k]*mx1[m][k] + a2e*mx2[m][k]
                      - b1[k]*my1[m][k] - b2e*my2[m][k]) >>> 6);
    endfunction

    task automatic model_clear();
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 3; k++) begin
                mx1[m][k] = 0; mx2[m][k] = 0; my1[m][k] = 0; my2[m][k] = 0;
            end
        mkreg = 0;
    endtask

    task automatic model_step(longint x);
        longint in_s[3], in_p, ny[2][3];
        in_s[0] = sat16((kg * x) >>> 6);
        in_s[1] = my1[0][0];
        in_s[2] = my1[0][1];
        in_p    = x;
        for (int k = 0; k < 3; k++) begin
            ny[0][k] = sec_eval(0, k, in_s[k]);
            ny[1][k] = sec_eval(1, k, in_p);
        end
        for (int k = 0; k < 3; k++) begin
            mx2[0][k] = mx1[0][k]; mx1[0][k] = in_s[k];
            my2[0][k] = my1[0][k]; my1[0][k] = ny[0][k];
            mx2[1][k] = mx1[1][k]; mx1[1][k] = in_p;
            my2[1][k] = my1[1][k]; my1[1][k] = ny[1][k];
        end
        mkreg = sat16((kg * x) >>> 6);
    endtask

    task automatic chk(string tag, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: yout=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at negedge, step on posedge, compare at next negedge
    task automatic tick(int x, bit en, bit rst, string ts, string tp);
        xin   = 8'(x);
        clken = en;
        srst  = rst;
        @(posedge clock);
        if (rst)     model_clear();
        else if (en) model_step(longint'(x));
        @(negedge clock);
        chk(ts, longint'(yout_s), my1[0][2]);
        chk(tp, longint'(yout_p),
            sat16(my1[1][0] + my1[1][1] + my1[1][2] + mkreg));
    endtask

    initial begin
        repeat (100000) @(posedge clock);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        model_clear();
        @(negedge clock);
        // R5: reset state
        tick(0, 1'b0, 1'b1, "R5 serial reset", "R5 parallel reset");
        tick(0, 1'b1, 1'b1, "R5 serial reset", "R5 parallel reset");
        // R7: zero input at rest
        for (int i = 0; i < 10; i++)
            tick(0, 1'b1, 1'b0, "R7 serial rest", "R7 parallel rest");
        // R3: impulse response of the sections
        tick(64, 1'b1, 1'b0, "R3 serial impulse", "R3 parallel impulse");
        for (int i = 0; i < 20; i++)
            tick(0, 1'b1, 1'b0, "R3 serial impulse", "R3 parallel impulse");
        // R2 / R4: full sweep of input values
        for (int v = -128; v < 128; v++)
            tick(v, 1'b1, 1'b0, "R2 serial sweep", "R4 parallel sweep");
        // R2 / R4: saturating drive at both extremes
        for (int i = 0; i < 30; i++)
            tick(127, 1'b1, 1'b0, "R2 serial saturate", "R4 parallel saturate");
        for (int i = 0; i < 30; i++)
            tick(-128, 1'b1, 1'b0, "R2 serial saturate", "R4 parallel saturate");
        // R1: pseudo-random data, tail coefficients a2/b2 must be ignored
        for (int i = 0; i < 300; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            tick(int'((seed >> 16) & 32'hFF) - 128, 1'b1, 1'b0,
                 "R1 serial random", "R4 parallel random");
        end
        // R6: enable toggling holds state when low
        for (int i = 0; i < 200; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            tick(int'((seed >> 16) & 32'hFF) - 128, seed[28], 1'b0,
                 "R6 serial gated", "R6 parallel gated");
        end
        // R5: reset wins over a low enable mid-run
        tick(99, 1'b0, 1'b1, "R5 serial reset priority", "R5 parallel reset priority");
        for (int i = 0; i < 10; i++)
            tick(0, 1'b1, 1'b0, "R7 serial rest after reset", "R7 parallel rest after reset");
        // R2: serial latency after reset, single sample then zeros
        tick(100, 1'b1, 1'b0, "R2 serial latency", "R4 parallel latency");
        for (int i = 0; i < 5; i++)
            tick(0, 1'b1, 1'b0, "R2 serial latency", "R4 parallel latency");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule